// File: doc/BRIEF.md
# Parallel Bellman Value Estimator

This block computes one Bellman backup term per clock cycle for a finite decision process. A lookup carries a state, an action and a precomputed immediate-return operand G. The block returns G plus the sum, over every next state, of a discounted transition weight times that next state's current value. There is one lane per next state, and every lane works on the same lookup at once. Each lane keeps its own table of 7-bit weight codes, indexed by the state-action pair. A lane expands its code to an 18-bit fixed-point weight, multiplies it by its own next-state value register, and passes the product into a balanced adder tree. The discount factor is already folded into the stored codes, so the datapath has no separate discount multiply.

All values are signed 18-bit fixed point with 16 fraction bits (range -2.0 to just under 2.0). The tree carries extra guard bits so that the full sum cannot overflow. A write port updates one value register per cycle, which lets a surrounding controller write back estimates while lookups continue. A second write port loads the per-lane weight tables. A valid bit and a state/action tag travel with the data, and the block never stalls.

Top module: `bellman_est`

## Requirements
- R1: Every cycle with `valid_i` high yields exactly one cycle with `valid_o` high, exactly LAT = 1 + MUL_LAT + LEVELS*ADD_LAT cycles later. LEVELS is ceil(log2(N_STATES+1)), so LAT is 22 with the defaults. Lookups may arrive back to back, and there are no spurious outputs.
- R2: Weight code k (0..127) decodes to floor((k*65536 + 63)/127) in the 16-fraction-bit format. Code 0 gives 0, and code 127 gives exactly 1.0 (65536).
- R3: `sum_o` equals G plus the sum over lanes j of floor(w_j * V_j / 65536). It is a signed value of width 18+LEVELS (22 bits by default), so the extreme inputs (all values and G at +131071, or all at -131072, with every code 127) come out exact.
- R4: `tag_o` returns {state, action} of the lookup it belongs to, with the state in the upper bits.
- R5: Lane j uses the code stored in its own table at address state*N_ACT + action. Lanes whose codes differ produce products that differ.
- R6: A value write (`val_we_i`, `val_idx_i`, `val_data_i`) updates register `val_idx_i`. A lookup accepted in the same cycle still uses the old value. A lookup in a later cycle uses the new one.
- R7: A weight write (`wt_we_i`, `wt_lane_i`, `wt_addr_i`, `wt_code_i`) changes only that lane's entry. The change is visible to any lookup accepted in a later cycle.
- R8: While reset is asserted, `valid_o` is low and `sum_o` is zero. After reset every value register reads zero, so a lookup returns just its G.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Lookup accepted this cycle |
| state_i | input | ST_W (3) | Current state of the lookup |
| action_i | input | ACT_W (2) | Action of the lookup |
| g_i | input | 18 | Precomputed immediate-return operand, signed Q2.16 |
| val_we_i | input | 1 | Value register write enable |
| val_idx_i | input | ST_W (3) | Value register to write |
| val_data_i | input | 18 | New value, signed Q2.16 |
| wt_we_i | input | 1 | Weight table write enable |
| wt_lane_i | input | ST_W (3) | Lane whose table is written |
| wt_addr_i | input | ADDR_W (5) | Table address, state*N_ACT + action |
| wt_code_i | input | 7 | Weight code |
| valid_o | output | 1 | Result valid |
| tag_o | output | ST_W+ACT_W (5) | {state, action} of the result |
| sum_o | output | 18+LEVELS (22) | Backup sum, signed, 16 fraction bits |

## Verification
The hardest case to reach from the ports is a value write that lands in the same cycle as a lookup reading that register, while older lookups are still in the pipeline. The stimulus drives the lookup and the write on one edge. The expected result for that lookup is computed from the old value, and the next lookup to the same pair is computed from the new one. Back-to-back table vectors keep up to LAT results in flight, so each output's tag and arrival cycle are matched against its own lookup. The extreme-magnitude corner is reached by reprogramming one table address to code 127 in every lane and driving every value register to full scale of each sign.

// File: rtl/bellman_pkg.sv
package bellman_pkg;
  localparam int VAL_W  = 18;
  localparam int FRAC_W = 16;
  localparam int CODE_W = 7;
  localparam int NUM_W  = CODE_W + FRAC_W + 1;
  localparam logic [NUM_W-1:0] CODE_MAX = NUM_W'(2**CODE_W - 1);
  localparam logic [NUM_W-1:0] CODE_HALF = NUM_W'((2**CODE_W - 1) / 2);

  // evenly spaced code -> Q2.16 weight in [0,1], rounded
  function automatic logic signed [VAL_W-1:0] decode_wt(input logic [CODE_W-1:0] c);
    logic [NUM_W-1:0] num;
    num = (NUM_W'(c) << FRAC_W) + CODE_HALF;
    return VAL_W'(num / CODE_MAX);
  endfunction
endpackage

// File: rtl/bellman_pipe.sv
module bellman_pipe #(
  parameter int W = 1,
  parameter int D = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [D];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < D; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < D; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[D-1];
endmodule

// File: rtl/bellman_lane.sv
module bellman_lane
  import bellman_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int ADDR_W  = 5,
  parameter int MUL_LAT = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  input  logic signed [VAL_W-1:0] val_i,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [CODE_W-1:0]       wr_code_i,
  output logic signed [VAL_W-1:0] prod_o
);
  logic [CODE_W-1:0]       mem [DEPTH];
  logic [CODE_W-1:0]       code_q;
  logic signed [VAL_W-1:0] val_q;
  logic signed [VAL_W-1:0] wt_c;
  logic signed [2*VAL_W-1:0] full_c;
  logic signed [VAL_W-1:0] prod_c;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_code_i;
  end

  // operand capture: value sampled before any same-edge write-back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      val_q  <= '0;
    end else begin
      code_q <= mem[rd_addr_i];
      val_q  <= val_i;
    end
  end

  always_comb begin
    wt_c   = decode_wt(code_q);
    full_c = wt_c * val_q;
    prod_c = VAL_W'(full_c >>> FRAC_W);
  end

  bellman_pipe #(.W(VAL_W), .D(MUL_LAT)) u_mul_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (prod_c),
    .q_o   (prod_o)
  );

  AST_DECODE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wt_c >= 0) && (wt_c <= (VAL_W'(1) <<< FRAC_W))); // R2
  AST_WT_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem[$past(wr_addr_i)] == $past(wr_code_i)); // R7
endmodule

// File: rtl/bellman_tree.sv
module bellman_tree #(
  parameter int ACC_W   = 22,
  parameter int LEVELS  = 4,
  parameter int ADD_LAT = 4,
  localparam int N_LEAF = 1 << LEVELS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_LEAF*ACC_W-1:0] leaves_i,
  output logic signed [ACC_W-1:0] sum_o
);
  logic [N_LEAF*ACC_W-1:0] lvl [LEVELS+1];

  assign lvl[0] = leaves_i;

  for (genvar l = 0; l < LEVELS; l++) begin : g_level
    localparam int NN = N_LEAF >> (l + 1);
    logic [N_LEAF*ACC_W-1:0] sum_c;

    always_comb begin
      sum_c = '0;
      for (int n = 0; n < NN; n++) begin
        sum_c[n*ACC_W +: ACC_W] = $signed(lvl[l][(2*n)*ACC_W +: ACC_W])
                                + $signed(lvl[l][(2*n+1)*ACC_W +: ACC_W]);
      end
    end

    bellman_pipe #(.W(N_LEAF*ACC_W), .D(ADD_LAT)) u_add_pipe (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (sum_c),
      .q_o   (lvl[l+1])
    );
  end

  assign sum_o = $signed(lvl[LEVELS][ACC_W-1:0]);
endmodule

// File: rtl/bellman_est.sv
module bellman_est
  import bellman_pkg::*;
#(
  parameter int N_STATES = 8,
  parameter int N_ACT    = 4,
  parameter int MUL_LAT  = 5,
  parameter int ADD_LAT  = 4,
  localparam int ST_W    = $clog2(N_STATES),
  localparam int ACT_W   = $clog2(N_ACT),
  localparam int DEPTH   = N_STATES * N_ACT,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int LEVELS  = $clog2(N_STATES + 1),
  localparam int ACC_W   = VAL_W + LEVELS,
  localparam int TAG_W   = ST_W + ACT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [ST_W-1:0]         state_i,
  input  logic [ACT_W-1:0]        action_i,
  input  logic signed [VAL_W-1:0] g_i,
  input  logic                    val_we_i,
  input  logic [ST_W-1:0]         val_idx_i,
  input  logic signed [VAL_W-1:0] val_data_i,
  input  logic                    wt_we_i,
  input  logic [ST_W-1:0]         wt_lane_i,
  input  logic [ADDR_W-1:0]       wt_addr_i,
  input  logic [CODE_W-1:0]       wt_code_i,
  output logic                    valid_o,
  output logic [TAG_W-1:0]        tag_o,
  output logic signed [ACC_W-1:0] sum_o
);
  localparam int N_LEAF = 1 << LEVELS;
  localparam int LAT    = 1 + MUL_LAT + LEVELS * ADD_LAT;
  localparam int CNT_W  = $clog2(LAT + 2);

  logic signed [VAL_W-1:0] val_q [N_STATES];
  logic signed [VAL_W-1:0] prod  [N_STATES];
  logic signed [VAL_W-1:0] g_dly;
  logic [ADDR_W-1:0]       rd_addr;
  logic [N_LEAF*ACC_W-1:0] leaves;

  assign rd_addr = ADDR_W'(state_i) * ADDR_W'(N_ACT) + ADDR_W'(action_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_STATES; i++) val_q[i] <= '0;
    end else if (val_we_i) begin
      val_q[val_idx_i] <= val_data_i;
    end
  end

  for (genvar j = 0; j < N_STATES; j++) begin : g_lane
    bellman_lane #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .MUL_LAT(MUL_LAT)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rd_addr_i(rd_addr),
      .val_i    (val_q[j]),
      .wr_en_i  (wt_we_i && (wt_lane_i == ST_W'(j))),
      .wr_addr_i(wt_addr_i),
      .wr_code_i(wt_code_i),
      .prod_o   (prod[j])
    );
  end

  // G joins the tree alongside the lane products
  bellman_pipe #(.W(VAL_W), .D(1 + MUL_LAT)) u_g_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (g_i),
    .q_o   (g_dly)
  );

  always_comb begin
    leaves = '0;
    for (int j = 0; j < N_STATES; j++) begin
      leaves[j*ACC_W +: ACC_W] = {{(ACC_W-VAL_W){prod[j][VAL_W-1]}}, prod[j]};
    end
    leaves[N_STATES*ACC_W +: ACC_W] = {{(ACC_W-VAL_W){g_dly[VAL_W-1]}}, g_dly};
  end

  bellman_tree #(.ACC_W(ACC_W), .LEVELS(LEVELS), .ADD_LAT(ADD_LAT)) u_tree (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .leaves_i(leaves),
    .sum_o   (sum_o)
  );

  bellman_pipe #(.W(1 + TAG_W), .D(LAT)) u_tag_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({valid_i, state_i, action_i}),
    .q_o   ({valid_o, tag_o})
  );

  logic [CNT_W-1:0] inflight_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else         inflight_q <= inflight_q + CNT_W'(valid_i) - CNT_W'(valid_o);
  end

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (inflight_q != '0)); // R1
  AST_INFLIGHT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= CNT_W'(LAT)); // R1
  AST_VAL_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    val_we_i |=> val_q[$past(val_idx_i)] == $past(val_data_i)); // R6
endmodule

// File: tb/bellman_est_test.sv
`timescale 1ns/1ps
module bellman_est_test;
  localparam int NS  = 8;
  localparam int NA  = 4;
  localparam int LAT = 22;

  typedef struct packed {
    logic [2:0]         st;
    logic [1:0]         act;
    logic signed [17:0] g;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 2'd0, 18'sd0},
    '{3'd0, 2'd1, 18'sd1000},
    '{3'd1, 2'd2, -18'sd2500},
    '{3'd2, 2'd3, 18'sd65536},
    '{3'd3, 2'd0, -18'sd70000},
    '{3'd5, 2'd1, 18'sd12345},
    '{3'd6, 2'd2, 18'sd131071},
    '{3'd7, 2'd3, -18'sd131072}
  };

  logic clk = 0, rst_n = 0;
  logic valid_i = 0, val_we = 0, wt_we = 0;
  logic [2:0] state_i = 0, val_idx = 0, wt_lane = 0;
  logic [1:0] action_i = 0;
  logic signed [17:0] g_i = 0, val_data = 0;
  logic [4:0] wt_addr = 0;
  logic [6:0] wt_code = 0;
  logic valid_o;
  logic [4:0] tag_o;
  logic signed [21:0] sum_o;

  always #4 clk = ~clk;

  bellman_est uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .state_i(state_i),
    .action_i(action_i), .g_i(g_i), .val_we_i(val_we), .val_idx_i(val_idx),
    .val_data_i(val_data), .wt_we_i(wt_we), .wt_lane_i(wt_lane),
    .wt_addr_i(wt_addr), .wt_code_i(wt_code), .valid_o(valid_o),
    .tag_o(tag_o), .sum_o(sum_o)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;
  logic [6:0] m_code [NS][NS*NA];
  longint m_val [NS];
  longint exp_sum [128];
  logic [4:0] exp_tag [128];
  int exp_cyc [128];
  int wr_ptr = 0, rd_ptr = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint dec(input logic [6:0] k);
    return (longint'(k) * 65536 + 63) / 127;
  endfunction

  function automatic longint model(input int st, input int act, input longint g);
    longint acc = g;
    for (int j = 0; j < NS; j++)
      acc += (dec(m_code[j][st*NA+act]) * m_val[j]) >>> 16;
    return acc;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act_v, input longint exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  // one cycle: optional lookup plus optional value write on the same edge
  task automatic step(input bit lk, input int st, input int act, input longint g,
                      input bit we, input int idx, input longint data);
    valid_i = lk; state_i = 3'(st); action_i = 2'(act); g_i = 18'(g);
    val_we = we; val_idx = 3'(idx); val_data = 18'(data);
    if (lk) begin
      exp_sum[wr_ptr] = model(st, act, g);
      exp_tag[wr_ptr] = {3'(st), 2'(act)};
      exp_cyc[wr_ptr] = cyc;
      wr_ptr++;
    end
    if (we) m_val[idx] = data;
    @(negedge clk);
    valid_i = 0; val_we = 0;
  endtask

  task automatic set_wt(input int lane, input int addr, input logic [6:0] c);
    wt_we = 1; wt_lane = 3'(lane); wt_addr = 5'(addr); wt_code = c;
    m_code[lane][addr] = c;
    @(negedge clk);
    wt_we = 0;
  endtask

  task automatic drain();
    repeat (LAT + 3) @(negedge clk);
    chk(rd_ptr == wr_ptr, "R1 all results returned", rd_ptr, wr_ptr);
  endtask

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (rd_ptr >= wr_ptr) begin
        chk(0, "R1 unexpected valid_o", 1, 0);
      end else begin
        chk(sum_o == 22'(exp_sum[rd_ptr]), "R3 sum", sum_o, exp_sum[rd_ptr]);
        chk(tag_o == exp_tag[rd_ptr], "R4 tag", tag_o, exp_tag[rd_ptr]);
        chk(cyc - exp_cyc[rd_ptr] == LAT, "R1 latency", cyc - exp_cyc[rd_ptr], LAT);
        rd_ptr++;
      end
    end
  end

  initial begin
    for (int j = 0; j < NS; j++) begin
      m_val[j] = 0;
      for (int a = 0; a < NS*NA; a++) m_code[j][a] = 0;
    end
    repeat (3) @(negedge clk);
    chk(valid_o == 0, "R8 valid_o in reset", valid_o, 0);
    chk(sum_o == 0, "R8 sum_o in reset", sum_o, 0);
    rst_n = 1;
    @(negedge clk);

    // R5 per-lane tables, address state*N_ACT+action
    for (int j = 0; j < NS; j++)
      for (int a = 0; a < NS*NA; a++)
        set_wt(j, a, 7'((j*37 + a*11 + 3) % 128));

    // R8 value registers zero after reset: result is G alone
    step(1, 4, 2, 777, 0, 0, 0);
    drain();

    for (int j = 0; j < NS; j++)
      step(0, 0, 0, 0, 1, j, (j % 2) ? -(j*9000) : j*15000 + 100);

    // table vectors, back to back (R1 R3 R4 R5)
    for (int i = 0; i < 8; i++)
      step(1, int'(VECS[i].st), int'(VECS[i].act), longint'(VECS[i].g), 0, 0, 0);
    drain();

    // R6 same-edge write-back: first lookup sees old value, second the new one
    step(1, 0, 0, 50, 1, 2, -100000);
    step(1, 0, 0, 50, 0, 0, 0);
    drain();

    // R7 weight rewrite visible to next lookup; neighbours unchanged
    set_wt(0, 1*NA+1, 7'd127);
    step(1, 1, 1, 0, 0, 0, 0);
    step(1, 1, 2, 0, 0, 0, 0);
    drain();

    // R2/R3 extremes: code 127 everywhere at address 31, full-scale values
    for (int j = 0; j < NS; j++) set_wt(j, 31, 7'd127);
    for (int j = 0; j < NS; j++) step(0, 0, 0, 0, 1, j, 131071);
    step(1, 7, 3, 131071, 0, 0, 0);
    for (int j = 0; j < NS; j++) step(0, 0, 0, 0, 1, j, -131072);
    step(1, 7, 3, -131072, 0, 0, 0);
    // R2 code 0 yields zero contribution
    for (int j = 0; j < NS; j++) set_wt(j, 30, 7'd0);
    step(1, 7, 2, 4321, 0, 0, 0);
    drain();
    chk(exp_sum[wr_ptr-3] == 1179639, "R3 max corner model", exp_sum[wr_ptr-3], 1179639);
    chk(exp_sum[wr_ptr-2] == -1179648, "R3 min corner model", exp_sum[wr_ptr-2], -1179648);
    chk(exp_sum[wr_ptr-1] == 4321, "R2 zero code model", exp_sum[wr_ptr-1], 4321);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule